// File: doc/BRIEF.md
# LED Token Write Bridge

This block connects one output of a dataflow network to a set of eight board indicator LEDs. Each LED sits behind a register on a shared Wishbone bus. Upstream logic offers 8-bit tokens over a valid/ready handshake. Each accepted token becomes exactly one single-word Wishbone write to a fixed LED register address. Bit i of the token lights LED i when it is 1 and darkens LED i when it is 0.

One small state machine runs both sides. In its idle state it raises ready. When a token is taken it captures the byte and opens a bus cycle. It holds that cycle until the slave acknowledges, and then returns to idle to take the next token. While a write is outstanding, ready stays low, so upstream sees backpressure.

The block is meant to sit on master port 0 of a two-master bus arbiter. The arbiter, the LED shift-register driver and the slave itself are outside the block. The reset input is asynchronous and active low. Its release is synchronised inside the block, so ready first rises two clock edges after the reset input goes high.

Top module: `led_token_bridge`

## Requirements
- R1: While reset is asserted, cyc, stb and ready are low. Two rising edges after the reset input is released, ready is high and no bus cycle is open. Asserting reset during a write drops cyc and stb at once.
- R2: A token is accepted on a rising edge where valid and ready are both high. After that edge, cyc, stb and we are high and ready is low.
- R3: While a write waits for ack, cyc and stb stay high and the address and data stay unchanged. This holds even if a new token is offered during the wait.
- R4: The write data carries the accepted byte in bits 7:0, with bit i driving LED i (1 = on, 0 = off), and bits 31:8 are zero.
- R5: During a write the address is the LED register address, 32'h0000_0004 by default, and the byte-select is 4'b0001, which enables only lane 0.
- R6: A rising edge with ack high during a write ends the cycle. After that edge, cyc and stb are low and ready is high.
- R7: An ack that arrives while no cycle is open has no effect. The block stays idle with ready high.
- R8: While valid is low in the idle state, no bus cycle starts.
- R9: A token that is held valid through the end of a write is taken after exactly one idle cycle with cyc low. The next write then carries that token's byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_data | input | 8 | Token byte, one bit per LED |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Block can take a token |
| wbm_cyc | output | 1 | Bus cycle open |
| wbm_stb | output | 1 | Bus strobe |
| wbm_we | output | 1 | Write enable |
| wbm_adr | output | 32 | Bus address |
| wbm_dat | output | 32 | Write data |
| wbm_sel | output | 4 | Byte-lane select |
| wbm_ack | input | 1 | Slave acknowledge |

## Verification
A token taken at a rising edge shows up on cyc, stb, we, address and data right after that same edge. Ready falls at that edge too. An ack sampled at an edge closes the cycle and restores ready right after that edge. Ready first rises two edges after the reset input is released. The bench drives inputs on falling edges and reads outputs on the following falling edge, one edge after the stimulus. The held-valid case is checked on two successive falling edges, to observe the single idle cycle and then the new write.

// File: rtl/led_bridge_pkg.sv
package led_bridge_pkg;
  typedef enum logic [0:0] {
    BR_IDLE  = 1'b0,
    BR_WRITE = 1'b1
  } bridge_state_e;
endpackage

// File: rtl/led_bridge_rst_sync.sv
module led_bridge_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/led_bridge_ctrl.sv
module led_bridge_ctrl
  import led_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tok_valid,
  input  logic bus_ack,
  output logic tok_ready,
  output logic load_en,
  output logic bus_active
);
  bridge_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    case (state_q)
      BR_IDLE: begin
        if (tok_valid) begin
          load_en = 1'b1;
          state_d = BR_WRITE;
        end
      end
      BR_WRITE: begin
        if (bus_ack) state_d = BR_IDLE;
      end
      default: state_d = BR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= BR_IDLE;
    else        state_q <= state_d;
  end

  assign tok_ready  = rst_n && (state_q == BR_IDLE);
  assign bus_active = (state_q == BR_WRITE);
endmodule

// File: rtl/led_bridge_payload.sv
module led_bridge_payload #(
  parameter int LED_COUNT = 8,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [LED_COUNT-1:0] tok_data,
  output logic [DATA_W-1:0]    bus_word,
  output logic [DATA_W/8-1:0]  bus_sel
);
  localparam int SEL_W = DATA_W / 8;

  logic [LED_COUNT-1:0] led_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       led_q <= '0;
    else if (load_en) led_q <= tok_data;
  end

  // bit i of the word drives LED i; bits above the LED field stay zero
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_word
      if (gi < LED_COUNT) begin : g_led
        assign bus_word[gi] = led_q[gi];
      end else begin : g_pad
        assign bus_word[gi] = 1'b0;
      end
    end
    for (gi = 0; gi < SEL_W; gi++) begin : g_sel
      assign bus_sel[gi] = ((gi * 8) < LED_COUNT);
    end
  endgenerate
endmodule

// File: rtl/led_token_bridge.sv
module led_token_bridge #(
  parameter int                LED_COUNT = 8,
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LED_ADDR  = 32'h0000_0004
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LED_COUNT-1:0] tok_data,
  input  logic                 tok_valid,
  output logic                 tok_ready,
  output logic                 wbm_cyc,
  output logic                 wbm_stb,
  output logic                 wbm_we,
  output logic [ADDR_W-1:0]    wbm_adr,
  output logic [DATA_W-1:0]    wbm_dat,
  output logic [DATA_W/8-1:0]  wbm_sel,
  input  logic                 wbm_ack
);
  logic rst_int_n;
  logic load_en;
  logic active;

  led_bridge_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  led_bridge_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tok_valid (tok_valid),
    .bus_ack   (wbm_ack),
    .tok_ready (tok_ready),
    .load_en   (load_en),
    .bus_active(active)
  );

  led_bridge_payload #(.LED_COUNT(LED_COUNT), .DATA_W(DATA_W)) u_pay (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (load_en),
    .tok_data(tok_data),
    .bus_word(wbm_dat),
    .bus_sel (wbm_sel)
  );

  assign wbm_cyc = active;
  assign wbm_stb = active;
  assign wbm_we  = active;
  assign wbm_adr = LED_ADDR;
endmodule

// File: rtl/led_token_bridge_chk.sv
module led_token_bridge_chk #(
  parameter int                LED_COUNT = 8,
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] LED_ADDR  = 32'h0000_0004
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LED_COUNT-1:0] tok_data,
  input logic                 tok_valid,
  input logic                 tok_ready,
  input logic                 wbm_cyc,
  input logic                 wbm_stb,
  input logic                 wbm_we,
  input logic [ADDR_W-1:0]    wbm_adr,
  input logic [DATA_W-1:0]    wbm_dat,
  input logic                 wbm_ack
);
  AST_ACCEPT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready) |=> (wbm_cyc && wbm_stb && wbm_we && !tok_ready)); // R2
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wbm_cyc && !wbm_ack) |=> (wbm_cyc && wbm_stb && $stable(wbm_dat) && $stable(wbm_adr))); // R3
  AST_BYTE_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_ready) |=> (wbm_dat[LED_COUNT-1:0] == $past(tok_data))); // R4
  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    wbm_cyc |-> (wbm_adr == LED_ADDR)); // R5
  AST_ACK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (wbm_cyc && wbm_ack) |=> (!wbm_cyc && !wbm_stb)); // R6
  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wbm_cyc && wbm_ack && !tok_valid) |=> !wbm_cyc); // R7
  AST_NO_SPURIOUS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wbm_cyc && !(tok_valid && tok_ready)) |=> !wbm_cyc); // R8
endmodule

bind led_token_bridge led_token_bridge_chk #(
  .LED_COUNT(LED_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_ADDR(LED_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tok_data (tok_data),
  .tok_valid(tok_valid),
  .tok_ready(tok_ready),
  .wbm_cyc  (wbm_cyc),
  .wbm_stb  (wbm_stb),
  .wbm_we   (wbm_we),
  .wbm_adr  (wbm_adr),
  .wbm_dat  (wbm_dat),
  .wbm_ack  (wbm_ack)
);

// File: tb/sim_led_token_bridge.sv
module sim_led_token_bridge;
  logic        clk;
  logic        rst_n;
  logic [7:0]  tok_data;
  logic        tok_valid;
  logic        tok_ready;
  logic        wbm_cyc, wbm_stb, wbm_we;
  logic [31:0] wbm_adr, wbm_dat;
  logic [3:0]  wbm_sel;
  logic        wbm_ack;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] EXP_ADDR = 32'h0000_0004;

  // {token byte, ack wait cycles}
  localparam logic [11:0] VEC [0:5] = '{
    {8'h00, 4'd0}, {8'hFF, 4'd1}, {8'h01, 4'd3},
    {8'h80, 4'd0}, {8'hA5, 4'd2}, {8'h5A, 4'd4}
  };

  led_token_bridge u0 (
    .clk(clk), .rst_n(rst_n), .tok_data(tok_data), .tok_valid(tok_valid),
    .tok_ready(tok_ready), .wbm_cyc(wbm_cyc), .wbm_stb(wbm_stb), .wbm_we(wbm_we),
    .wbm_adr(wbm_adr), .wbm_dat(wbm_dat), .wbm_sel(wbm_sel), .wbm_ack(wbm_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_open(input logic [7:0] b, input string req);
    chk(wbm_cyc && wbm_stb && wbm_we, req, {29'd0, wbm_cyc, wbm_stb, wbm_we}, 32'd7);
    chk(!tok_ready, req, {31'd0, tok_ready}, 32'd0);
    chk(wbm_dat == {24'd0, b}, {req, "/R4"}, wbm_dat, {24'd0, b});
    chk(wbm_adr == EXP_ADDR && wbm_sel == 4'b0001, {req, "/R5"}, wbm_adr ^ {28'd0, wbm_sel ^ 4'b0001}, EXP_ADDR);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_data = '0; wbm_ack = 1'b0;
    #1;
    chk(!wbm_cyc && !wbm_stb && !tok_ready, "R1 in reset", {29'd0, wbm_cyc, wbm_stb, tok_ready}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tok_ready, "R1 sync window", {31'd0, tok_ready}, 32'd0);
    @(negedge clk);
    chk(tok_ready && !wbm_cyc, "R1 after release", {30'd0, tok_ready, wbm_cyc}, 32'd2);

    // R8: idle with valid low
    repeat (4) @(negedge clk);
    chk(!wbm_cyc && tok_ready, "R8 idle no cycle", {30'd0, wbm_cyc, tok_ready}, 32'd1);

    // vector table
    for (int v = 0; v < 6; v++) begin
      logic [7:0] b;
      int wait_n;
      b = VEC[v][11:4];
      wait_n = int'(VEC[v][3:0]);
      tok_data = b; tok_valid = 1'b1;
      @(negedge clk);
      tok_valid = 1'b0;
      check_open(b, "R2 accept");
      for (int w = 0; w < wait_n; w++) begin
        tok_valid = 1'b1; tok_data = ~b;   // offered while busy
        @(negedge clk);
        chk(wbm_cyc && wbm_dat == {24'd0, b} && !tok_ready, "R3 wait",
            wbm_dat, {24'd0, b});
      end
      tok_valid = 1'b0;
      wbm_ack = 1'b1;
      @(negedge clk);
      wbm_ack = 1'b0;
      chk(!wbm_cyc && !wbm_stb && tok_ready, "R6 ack close",
          {29'd0, wbm_cyc, wbm_stb, tok_ready}, 32'd1);
    end

    // R7: ack while idle
    wbm_ack = 1'b1;
    @(negedge clk);
    wbm_ack = 1'b0;
    chk(!wbm_cyc && tok_ready, "R7 idle ack", {30'd0, wbm_cyc, tok_ready}, 32'd1);
    @(negedge clk);
    chk(!wbm_cyc && wbm_dat == 32'h5A, "R7 state kept", wbm_dat, 32'h5A);

    // R9: held valid across end of write
    tok_data = 8'h3C; tok_valid = 1'b1;
    @(negedge clk);
    check_open(8'h3C, "R9 first");
    tok_data = 8'hC3;
    wbm_ack = 1'b1;
    @(negedge clk);
    wbm_ack = 1'b0;
    chk(!wbm_cyc && tok_ready, "R9 one idle cycle", {30'd0, wbm_cyc, tok_ready}, 32'd1);
    @(negedge clk);
    tok_valid = 1'b0;
    check_open(8'hC3, "R9 second");
    wbm_ack = 1'b1;
    @(negedge clk);
    wbm_ack = 1'b0;

    // R1: reset during a write
    tok_data = 8'h77; tok_valid = 1'b1;
    @(negedge clk);
    tok_valid = 1'b0;
    chk(wbm_cyc, "R1 pre-reset write", {31'd0, wbm_cyc}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk(!wbm_cyc && !wbm_stb && !tok_ready, "R1 reset mid write",
        {29'd0, wbm_cyc, wbm_stb, tok_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tok_ready && !wbm_cyc && wbm_dat == 32'd0, "R1 recovered", wbm_dat, 32'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule